// File: doc/BRIEF.md
# Cascaded Two-Bank Interrupt Controller

This block gathers interrupt events into two 32-bit pending banks and drives one fast-interrupt request line to the processor. Each bank has its own 32-bit enable mask. The pending and mask registers are never written directly. Instead, each one has a set address and a clear address. A one written to the set address raises the matching bit, and a one written to the clear address lowers it. Bits written as zero are left alone, so a handler never needs a read-modify-write sequence.

Hardware sources pulse bits into either bank. The second bank is folded into the most significant bit of the first bank as a summary. That bit is high exactly when any raw pending bit of the second bank is set. Enabling the summary bit in mask 0 therefore lets the whole second bank reach the processor through bank 0. The request output is a registered level. It changes on the clock edge that updates the registers.

Bank 0 source positions are fixed as follows:
- bit 30: software interrupt
- bit 29: expansion DMA
- bit 11: DSP
- bits 10 to 6: timers 1, 3, 5, 7 and 9
- bits 1 and 0: vertical interrupts 1 and 0

Bank 1 uses bit 1 for disk insertion and bit 0 for player-bus DMA.

Top module: `irqc_top`

## Requirements
- R1: A write to byte offset 0x40 ORs the write data into pending bank 0. A write to 0x44 clears every bank 0 pending bit where the data has a one. Bits 30..0 are affected, and the result is visible after the write edge.
- R2: A write to 0x48 ORs the data into mask 0. A write to 0x4C clears the mask 0 bits where the data has ones. All 32 bits are affected.
- R3: Offsets 0x60, 0x64, 0x68 and 0x6C perform set-pending, clear-pending, set-mask and clear-mask on bank 1 in the same way.
- R4: Pending bank 0 bit 31 equals the OR of all raw (unmasked) bank 1 pending bits in every cycle. Software writes to bit 31 at 0x40 or 0x44 have no effect on it.
- R5: `fiqReq` is high exactly when (pending0 AND mask0) or (pending1 AND mask1) is nonzero. It updates on the same edge as the registers, one cycle after the write or source pulse.
- R6: A one on `srcSet0[i]` sets pending bank 0 bit i, for i from 0 to 30. A one on `srcSet1[i]` sets pending bank 1 bit i.
- R7: When a source pulse and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R8: Reading 0x40 or 0x44 returns pending 0, and reading 0x48 or 0x4C returns mask 0. The bank 1 offsets 0x60 to 0x6C behave the same way for bank 1. Any other offset reads zero, and a write to any other offset changes nothing.
- R9: After reset, all pending and mask bits are zero and `fiqReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for the register bus |
| busAddr | input | 8 | Byte offset of the register access |
| busWrData | input | 32 | Write data (set or clear pattern) |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| srcSet0 | input | 31 | Hardware set pulses for pending bank 0 bits 30..0 |
| srcSet1 | input | 32 | Hardware set pulses for pending bank 1 |
| fiqReq | output | 1 | Fast-interrupt request level |

## Verification
Two functions can fall in the same cycle:
- a hardware source pulse setting a pending bit, and
- a software clear write aimed at that same bit.

The bench provokes this in a directed step that clears a bit while its source is pulsing. It also provokes it throughout the random phase, where source pulses land on the same cycles as random clear writes to both banks. A bench model applies the clear first and then ORs in the source pulses. Every register is read back afterwards and compared against that model, which judges that no event is lost. The summary bit and the request level are checked from the same model at the same time.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int NUM_BANKS = 2;

  // Register window base per bank; sub-offsets 0x0 set-pend, 0x4 clr-pend,
  // 0x8 set-mask, 0xC clr-mask.
  localparam logic [ADDR_W-1:0] BANK0_BASE = 8'h40;
  localparam logic [ADDR_W-1:0] BANK1_BASE = 8'h60;

  // Source positions in bank 0 and bank 1
  localparam int B0_CASCADE  = 31;
  localparam int B0_SOFTWARE = 30;
  localparam int B0_EXP_DMA  = 29;
  localparam int B0_DSP      = 11;
  localparam int B0_TIMER1   = 10;
  localparam int B0_TIMER9   = 6;
  localparam int B0_VERT1    = 1;
  localparam int B0_VERT0    = 0;
  localparam int B1_DISK     = 1;
  localparam int B1_PLAYER   = 0;

  typedef struct packed {
    logic setPend;
    logic clrPend;
    logic setMask;
    logic clrMask;
  } bankStrobe_t;

  typedef struct packed {
    bankStrobe_t [NUM_BANKS-1:0] bank;
    logic                        rdValid;
    logic                        rdBank;
    logic                        rdMask;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          busWrEn,
  input  logic [AW-1:0] busAddr,
  output ctrlStrobe_t   strobes
);
  localparam int SUB_LSB = 2;
  localparam int WIN_LSB = 4;

  logic [NUM_BANKS-1:0] bankHit;
  logic [1:0]           subSel;
  logic                 aligned;

  assign subSel  = busAddr[WIN_LSB-1:SUB_LSB];
  assign aligned = (busAddr[SUB_LSB-1:0] == '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    logic [AW-1:0] base;
    assign base       = (b == 0) ? BANK0_BASE : BANK1_BASE;
    assign bankHit[b] = aligned && (busAddr[AW-1:WIN_LSB] == base[AW-1:WIN_LSB]);

    always_comb begin
      strobes.bank[b].setPend = busWrEn && bankHit[b] && (subSel == 2'd0);
      strobes.bank[b].clrPend = busWrEn && bankHit[b] && (subSel == 2'd1);
      strobes.bank[b].setMask = busWrEn && bankHit[b] && (subSel == 2'd2);
      strobes.bank[b].clrMask = busWrEn && bankHit[b] && (subSel == 2'd3);
    end
  end

  always_comb begin
    strobes.rdValid = |bankHit;
    strobes.rdBank  = bankHit[1];
    strobes.rdMask  = subSel[1];
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int W           = DATA_W,
  parameter bit HAS_SUMMARY = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  bankStrobe_t  strb,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] hwSet,
  input  logic         summaryIn,
  output logic [W-1:0] pendQ,
  output logic [W-1:0] maskQ,
  output logic [W-1:0] pendNext,
  output logic [W-1:0] maskNext
);
  logic [W-1:0] pendCore;

  always_comb begin
    pendCore = pendQ;
    if (strb.clrPend) pendCore = pendCore & ~wrData;
    if (strb.setPend) pendCore = pendCore | wrData;
    pendCore = pendCore | hwSet;            // source pulse beats a clear
    pendNext = pendCore;
    pendNext[W-1] = HAS_SUMMARY ? summaryIn : pendCore[W-1];
  end

  always_comb begin
    maskNext = maskQ;
    if (strb.clrMask) maskNext = maskNext & ~wrData;
    if (strb.setMask) maskNext = maskNext | wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      maskQ <= '0;
    end else begin
      pendQ <= pendNext;
      maskQ <= maskNext;
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobe_t  strobes,
  input  logic [W-1:0] wrData,
  input  logic [W-2:0] hwSet0,
  input  logic [W-1:0] hwSet1,
  output logic [W-1:0] rdData,
  output logic         fiqReq,
  output logic [W-1:0] pend0,
  output logic [W-1:0] mask0,
  output logic [W-1:0] pend1,
  output logic [W-1:0] mask1
);
  logic [W-1:0] pendNext0, maskNext0, pendNext1, maskNext1;
  logic         cascade;

  assign cascade = |pendNext1;

  irqc_bank #(.W(W), .HAS_SUMMARY(1'b1)) bank0_i (
    .clk(clk), .rstN(rstN), .strb(strobes.bank[0]), .wrData(wrData),
    .hwSet({1'b0, hwSet0}), .summaryIn(cascade),
    .pendQ(pend0), .maskQ(mask0), .pendNext(pendNext0), .maskNext(maskNext0)
  );

  irqc_bank #(.W(W), .HAS_SUMMARY(1'b0)) bank1_i (
    .clk(clk), .rstN(rstN), .strb(strobes.bank[1]), .wrData(wrData),
    .hwSet(hwSet1), .summaryIn(1'b0),
    .pendQ(pend1), .maskQ(mask1), .pendNext(pendNext1), .maskNext(maskNext1)
  );

  always_ff @(posedge clk) begin
    if (!rstN) fiqReq <= 1'b0;
    else       fiqReq <= (|(pendNext0 & maskNext0)) || (|(pendNext1 & maskNext1));
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdValid) begin
      unique case ({strobes.rdBank, strobes.rdMask})
        2'b00: rdData = pend0;
        2'b01: rdData = mask0;
        2'b10: rdData = pend1;
        2'b11: rdData = mask1;
      endcase
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWrEn,
  input  logic [AW-1:0] busAddr,
  input  logic [W-1:0]  busWrData,
  output logic [W-1:0]  busRdData,
  input  logic [W-2:0]  srcSet0,
  input  logic [W-1:0]  srcSet1,
  output logic          fiqReq
);
  ctrlStrobe_t  strobes;
  logic [W-1:0] pend0, mask0, pend1, mask1;

  irqc_ctrl #(.AW(AW)) ctrl_i (
    .busWrEn(busWrEn), .busAddr(busAddr), .strobes(strobes)
  );

  irqc_datapath #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(busWrData),
    .hwSet0(srcSet0), .hwSet1(srcSet1), .rdData(busRdData), .fiqReq(fiqReq),
    .pend0(pend0), .mask0(mask0), .pend1(pend1), .mask1(mask1)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          busWrEn,
  input logic [AW-1:0] busAddr,
  input logic [W-1:0]  busWrData,
  input logic [W-2:0]  srcSet0,
  input logic [W-1:0]  srcSet1,
  input logic          fiqReq,
  input logic [W-1:0]  pend0,
  input logic [W-1:0]  mask0,
  input logic [W-1:0]  pend1,
  input logic [W-1:0]  mask1
);
  AST_PEND0_SET: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 8'h40) |=> ((pend0[W-2:0] & $past(busWrData[W-2:0])) == $past(busWrData[W-2:0]))); // R1
  AST_PEND0_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 8'h44) |=> ((pend0[W-2:0] & $past(busWrData[W-2:0]) & ~$past(srcSet0)) == '0)); // R1
  AST_MASK0_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 8'h4C) |=> ((mask0 & $past(busWrData)) == '0)); // R2
  AST_MASK1_SET: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 8'h68) |=> ((mask1 & $past(busWrData)) == $past(busWrData))); // R3
  AST_CASCADE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    pend0[W-1] == (pend1 != '0)); // R4
  AST_REQ_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    fiqReq == ((|(pend0 & mask0)) || (|(pend1 & mask1)))); // R5
  AST_SOURCE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (srcSet1 != '0) |=> ((pend1 & $past(srcSet1)) == $past(srcSet1))); // R7
endmodule

bind irqc_top irqc_checker #(.W(W), .AW(AW)) chk_i (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .srcSet0(srcSet0), .srcSet1(srcSet1),
  .fiqReq(fiqReq), .pend0(pend0), .mask0(mask0), .pend1(pend1), .mask1(mask1)
);

// File: tb/irqc_tb.sv
module irqc_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [30:0] srcSet0 = '0;
  logic [31:0] srcSet1 = '0;
  logic        fiqReq;

  int nChecks = 0;
  int nFails  = 0;

  // bench model
  logic [30:0] mP0 = '0;
  logic [31:0] mP1 = '0, mM0 = '0, mM1 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .srcSet0(srcSet0),
    .srcSet1(srcSet1), .fiqReq(fiqReq)
  );

  function automatic logic [31:0] expPend0();
    return {|mP1, mP0};
  endfunction

  function automatic logic expReq();
    return (|(expPend0() & mM0)) || (|(mP1 & mM1));
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h40, 8'h44: return expPend0();
      8'h48, 8'h4C: return mM0;
      8'h60, 8'h64: return mP1;
      8'h68, 8'h6C: return mM1;
      default:      return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  // one bus cycle: write (optional) plus source pulses, model updated after
  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic [30:0] s0, input logic [31:0] s1);
    @(negedge clk);
    busWrEn = we; busAddr = a; busWrData = d; srcSet0 = s0; srcSet1 = s1;
    @(negedge clk);
    busWrEn = 1'b0; srcSet0 = '0; srcSet1 = '0;
    if (we) begin
      case (a)
        8'h40: mP0 = mP0 | d[30:0];
        8'h44: mP0 = mP0 & ~d[30:0];
        8'h48: mM0 = mM0 | d;
        8'h4C: mM0 = mM0 & ~d;
        8'h60: mP1 = mP1 | d;
        8'h64: mP1 = mP1 & ~d;
        8'h68: mM1 = mM1 | d;
        8'h6C: mM1 = mM1 & ~d;
        default: ;
      endcase
    end
    mP0 = mP0 | s0;
    mP1 = mP1 | s1;
  endtask

  task automatic verifyAll(input string tag);
    logic [7:0] offs [9] = '{8'h40, 8'h44, 8'h48, 8'h4C, 8'h60, 8'h64, 8'h68, 8'h6C, 8'h50};
    check({tag, " R5 fiqReq"}, {31'b0, fiqReq}, {31'b0, expReq()});
    for (int i = 0; i < 9; i++) begin
      busAddr = offs[i];
      #1;
      check($sformatf("%s R8 read %02h", tag, offs[i]), busRdData, expRead(offs[i]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog R9 got=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9 reset state
    verifyAll("R9 reset");

    // R1 set/clear pending 0, bit 31 write ignored (R4)
    step(1, 8'h40, 32'h8000_0C03, '0, '0);
    check("R4 bit31 ignored", expPend0() & 32'h8000_0000, 32'h0);
    verifyAll("R1 set");
    step(1, 8'h44, 32'h0000_0401, '0, '0);
    verifyAll("R1 clr");
    // R2 mask 0, request via DSP bit
    step(1, 8'h48, 32'h0000_0800, '0, '0);
    verifyAll("R2 R5 req on");
    step(1, 8'h4C, 32'h0000_0800, '0, '0);
    verifyAll("R2 R5 req off");
    // R3 R4 cascade through bank 1 disk bit
    step(1, 8'h48, 32'h8000_0000, '0, '0);
    step(0, 8'h00, 32'h0, '0, 32'h0000_0002);
    verifyAll("R4 R6 cascade on");
    step(1, 8'h44, 32'h8000_0000, '0, '0);
    verifyAll("R4 clr bit31 ignored");
    step(1, 8'h64, 32'h0000_0002, '0, '0);
    verifyAll("R3 R4 cascade off");
    // R7 set beats clear in same cycle
    step(1, 8'h44, 32'h4000_0000, 31'h4000_0000, '0);
    verifyAll("R7 bank0 race");
    step(1, 8'h64, 32'h0000_0001, '0, 32'h0000_0001);
    verifyAll("R7 bank1 race");
    // R8 unmapped write has no effect
    step(1, 8'h50, 32'hFFFF_FFFF, '0, '0);
    verifyAll("R8 unmapped write");

    // random phase
    for (int n = 0; n < 400; n++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic [30:0] s0;
      logic [31:0] s1;
      logic [7:0] legal [8] = '{8'h40, 8'h44, 8'h48, 8'h4C, 8'h60, 8'h64, 8'h68, 8'h6C};
      a  = ($urandom % 10 == 0) ? 8'($urandom) : legal[$urandom % 8];
      d  = ($urandom % 2) ? $urandom : ($urandom & $urandom & $urandom);
      s0 = ($urandom % 3 == 0) ? 31'($urandom & $urandom & $urandom) : '0;
      s1 = ($urandom % 3 == 0) ? ($urandom & $urandom & $urandom) : '0;
      step($urandom % 8 != 0, a, d, s0, s1);
      verifyAll("R6 R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule